// File: doc/BRIEF.md
# Power-Down and Offset-Calibration Sequencer

This block sequences power-down and offset calibration for the output stage of an audio decimation filter. It runs on the system clock, which is 256 or 384 times the sample rate. Upstream logic reduces that clock to a one-cycle sample strobe, so the sequencer itself only counts strobes. An active-low power-down request is qualified against glitches. Once accepted, the block raises a calibration flag and forces the serial data output to zero at once.

When the request is released, the block counts a fixed calibration interval of sample periods. At the end of that interval it drops the calibration flag and latches a rounded average of an external accumulated-sum input as the stored offset. It then holds the data invalid for one more sample period before it lets serial data through. A synchronous reset starts a calibration directly, as though a power-down had just ended. All outputs are registered.

Top module: `pdcal_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cal_o`=1, `dvalid_o`=0, `sdata_o`=0 and `ofs_o`=0. A calibration interval starts counting from zero when reset ends.
- R2: When `pd_n` is low at two consecutive rising clock edges, then after the second edge `cal_o`=1, `dvalid_o`=0 and `sdata_o`=0. This is well inside the 6-cycle limit.
- R3: A `pd_n` low pulse that lasts a single clock edge has no effect. The outputs do not change and calibration progress is kept.
- R4: While an accepted power-down is held (`pd_n` low), `cal_o` stays 1 and sample strobes are not counted.
- R5: After power-down is released, or after reset, `cal_o` stays 1 through 4095 sample strobes. It goes to 0 in the cycle after the 4096th strobe edge (count value 4095).
- R6: `dvalid_o` stays 0 after calibration ends and rises only after the next sample strobe edge. That is exactly one sample period later.
- R7: When `dvalid_o`=1, `sdata_o` equals `sdata_i` as registered at the previous edge. Otherwise `sdata_o` is 0.
- R8: At the end of calibration, `ofs_o` takes `(acc_i + 2^11) >> 12`, saturated to all ones on overflow. It holds that value until the next calibration ends.
- R9: An accepted power-down during calibration restarts the sample count. A full 4096 strobes are needed after the release.
- R10: `cal_o` and `dvalid_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (256x or 384x sample rate) |
| rst | input | 1 | Synchronous active-high reset; starts a calibration |
| smp_stb | input | 1 | One-clock pulse per sample period |
| pd_n | input | 1 | Active-low power-down request |
| sdata_i | input | 1 | Serial data from the filter |
| acc_i | input | 28 | Accumulated offset sum over the calibration interval |
| cal_o | output | 1 | High while powered down or calibrating |
| dvalid_o | output | 1 | High once output data is valid |
| sdata_o | output | 1 | Gated serial data, zero while invalid |
| ofs_o | output | 16 | Latched averaged offset |

## Verification
The calibration interval is counted through three times. The first count follows reset and has a one-edge glitch on `pd_n` in the middle. The second follows a held power-down. The third follows a power-down that interrupts an interval 100 strobes in. Sampling `cal_o` after strobe 4095 and after strobe 4096 separates an off-by-one count from a correct one. In the third pass, a design that kept its count through the interruption would end calibration early. A glitch in the running state and another during calibration separate a qualified request from a raw one. The two offset sums, one that rounds down and one that rounds up, separate a rounded average from a truncated one.

// File: rtl/pdcal_pkg.sv
package pdcal_pkg;
  typedef enum logic [1:0] {
    ST_PWRDN = 2'd0,
    ST_CALIB = 2'd1,
    ST_GUARD = 2'd2,
    ST_LIVE  = 2'd3
  } pdcal_state_e;
endpackage

// File: rtl/pdcal_pd_qual.sv
module pdcal_pd_qual #(
  parameter int MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_n,
  output logic hit
);
  localparam int RW = $clog2(MIN_LOW + 1);
  localparam logic [RW-1:0] THR = RW'(MIN_LOW - 1);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (pd_n) begin
      run_q <= '0;
    end else if (run_q < THR) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign hit = !pd_n && (run_q >= THR);

  // R3
  run_reset_chk: assert property (@(posedge clk) disable iff (rst)
    pd_n |=> (run_q == '0));
endmodule

// File: rtl/pdcal_smp_cnt.sv
module pdcal_smp_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic             last,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign last = (cnt == CNT_MAX);

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt) |-> (cnt == '0 || cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/pdcal_ofs_latch.sv
module pdcal_ofs_latch #(
  parameter int OFS_W = 16,
  parameter int CNT_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cap,
  input  logic [OFS_W+CNT_W-1:0] acc,
  output logic [OFS_W-1:0]       ofs
);
  localparam int ACC_W = OFS_W + CNT_W;
  localparam logic [ACC_W:0] HALF = (ACC_W + 1)'(1) << (CNT_W - 1);

  logic [ACC_W:0]   rsum;
  logic [OFS_W-1:0] avg;

  always_comb begin
    rsum = {1'b0, acc} + HALF;
    avg  = rsum[ACC_W] ? {OFS_W{1'b1}} : rsum[ACC_W-1:CNT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs <= '0;
    end else if (cap) begin
      ofs <= avg;
    end
  end

  // R8
  ofs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cap) |-> $stable(ofs));
endmodule

// File: rtl/pdcal_seq.sv
module pdcal_seq #(
  parameter int CNT_W   = 12,
  parameter int OFS_W   = 16,
  parameter int MIN_LOW = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   smp_stb,
  input  logic                   pd_n,
  input  logic                   sdata_i,
  input  logic [OFS_W+CNT_W-1:0] acc_i,
  output logic                   cal_o,
  output logic                   dvalid_o,
  output logic                   sdata_o,
  output logic [OFS_W-1:0]       ofs_o
);
  import pdcal_pkg::*;

  pdcal_state_e st_q, st_d;
  logic pd_hit, cnt_last, cnt_clr, cnt_inc, cap;
  logic [CNT_W-1:0] cnt;

  pdcal_pd_qual #(.MIN_LOW(MIN_LOW)) u_qual (
    .clk(clk), .rst(rst), .pd_n(pd_n), .hit(pd_hit)
  );

  pdcal_smp_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
    .last(cnt_last), .cnt(cnt)
  );

  pdcal_ofs_latch #(.OFS_W(OFS_W), .CNT_W(CNT_W)) u_ofs (
    .clk(clk), .rst(rst), .cap(cap), .acc(acc_i), .ofs(ofs_o)
  );

  always_comb begin
    st_d = st_q;
    if (pd_hit) begin
      st_d = ST_PWRDN;
    end else begin
      case (st_q)
        ST_PWRDN: if (pd_n) st_d = ST_CALIB;
        ST_CALIB: if (smp_stb && cnt_last) st_d = ST_GUARD;
        ST_GUARD: if (smp_stb) st_d = ST_LIVE;
        default:  st_d = ST_LIVE;
      endcase
    end
  end

  assign cnt_clr = pd_hit || (st_q != ST_CALIB);
  assign cnt_inc = (st_q == ST_CALIB) && smp_stb && !cnt_last;
  assign cap     = !pd_hit && (st_q == ST_CALIB) && smp_stb && cnt_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_CALIB;
      cal_o    <= 1'b1;
      dvalid_o <= 1'b0;
      sdata_o  <= 1'b0;
    end else begin
      st_q     <= st_d;
      cal_o    <= (st_d == ST_PWRDN) || (st_d == ST_CALIB);
      dvalid_o <= (st_d == ST_LIVE);
      sdata_o  <= (st_d == ST_LIVE) && sdata_i;
    end
  end

  // R2
  pd_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (!pd_n && !$past(pd_n) && !$past(rst)) |=> (cal_o && !dvalid_o && !sdata_o));
  // R4
  pd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PWRDN && !pd_n) |-> (cnt == '0 && cal_o));
  // R5
  cal_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cal_o) |-> $past(smp_stb));
  // R6
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dvalid_o) |-> ($past(smp_stb) && !$past(cal_o)));
  // R7
  blank_data_chk: assert property (@(posedge clk) disable iff (rst)
    !dvalid_o |-> !sdata_o);
  // R10
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(cal_o && dvalid_o));
endmodule

// File: tb/pdcal_seq_tb.sv
`timescale 1ns/1ps
module pdcal_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_stb = 1'b0;
  logic pd_n = 1'b1;
  logic sdata_i = 1'b1;
  logic [27:0] acc_i = '0;
  logic cal_o, dvalid_o, sdata_o;
  logic [15:0] ofs_o;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pdcal_seq u_dut (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .pd_n(pd_n),
    .sdata_i(sdata_i), .acc_i(acc_i), .cal_o(cal_o),
    .dvalid_o(dvalid_o), .sdata_o(sdata_o), .ofs_o(ofs_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      smp_stb = 1'b1;
      @(negedge clk);
      smp_stb = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic glitch();
    pd_n = 1'b0;
    @(negedge clk);
    pd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 cal in reset", cal_o, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cal", cal_o, 1);
    chk("R1 dvalid", dvalid_o, 0);
    chk("R1 sdata", sdata_o, 0);
    chk("R1 ofs", ofs_o, 0);
  endtask

  task automatic t_first_cal();
    acc_i = 28'h5A51234;
    strobes(2000);
    glitch();
    chk("R3 glitch in cal keeps cal", cal_o, 1);
    strobes(2095);
    chk("R5 cal after 4095 (R3 glitch ignored)", cal_o, 1);
    chk("R5 dvalid still low", dvalid_o, 0);
    strobes(1);
    chk("R5 cal falls after 4096th", cal_o, 0);
    chk("R6 dvalid low one more sample", dvalid_o, 0);
    chk("R7 sdata blanked", sdata_o, 0);
    chk("R8 ofs rounded down", ofs_o, 16'h5A51);
    chk("R10 exclusive", cal_o & dvalid_o, 0);
    strobes(1);
    chk("R6 dvalid after extra sample", dvalid_o, 1);
    chk("R7 sdata passes 1", sdata_o, 1);
    sdata_i = 1'b0;
    @(negedge clk);
    chk("R7 sdata passes 0", sdata_o, 0);
    sdata_i = 1'b1;
    @(negedge clk);
    chk("R7 sdata back to 1", sdata_o, 1);
  endtask

  task automatic t_run_glitch();
    glitch();
    chk("R3 run glitch dvalid", dvalid_o, 1);
    chk("R3 run glitch cal", cal_o, 0);
    chk("R3 run glitch sdata", sdata_o, 1);
  endtask

  task automatic t_powerdown();
    pd_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 cal on pd", cal_o, 1);
    chk("R2 dvalid off", dvalid_o, 0);
    chk("R2 sdata zero", sdata_o, 0);
    acc_i = 28'h0000001;
    strobes(5);
    chk("R4 held cal", cal_o, 1);
    chk("R8 ofs held in pd", ofs_o, 16'h5A51);
    pd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_restart();
    acc_i = 28'hC3C3FFF;
    strobes(100);
    pd_n = 1'b0;
    repeat (2) @(negedge clk);
    pd_n = 1'b1;
    @(negedge clk);
    strobes(4095);
    chk("R9 cal after restart 4095", cal_o, 1);
    chk("R8 ofs unchanged mid cal", ofs_o, 16'h5A51);
    strobes(1);
    chk("R9 cal falls after full count", cal_o, 0);
    chk("R8 ofs rounded up", ofs_o, 16'hC3C4);
    acc_i = 28'h0;
    strobes(1);
    chk("R6 dvalid after restart", dvalid_o, 1);
    chk("R8 ofs holds", ofs_o, 16'hC3C4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_first_cal();
    t_run_glitch();
    t_powerdown();
    t_restart();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule